// File: doc/BRIEF.md
# Issue Queue Wakeup and Select

This block is the scheduling window of an out-of-order core. Each slot holds one waiting instruction: a left and a right source tag, each with a ready flag, plus the tag of the result it will produce and the class of operation. Every cycle, result tags are compared against every source in the window. A matching source becomes ready. A slot asks to issue when both its sources are ready. Selection stages, one per functional unit, each a binary tree of arbiter cells, grant up to one slot each. Each stage ignores the slots that earlier stages have already taken. Among the slots that ask, the lowest index is always served first.

Single-cycle operations announce their result tag in the cycle they are granted, so a dependent can issue on the very next cycle. Multi-cycle operations wait for the external broadcast instead. Loads also announce their tag when granted, on the assumption that they hit in the cache. Sources woken this way are marked speculative. A slot that issued on a speculative source stays in the window until the load's outcome arrives. A hit releases the slot. A miss squashes it: the speculative source goes back to not-ready and the slot waits for the load's real result tag. Dispatch writes a slot chosen by the front end, and its sources also see the broadcasts of that same cycle.

Top module: `iq_wakeup_select`

## Requirements
- R1: After a synchronous active-low reset the window is empty and no functional unit output reports an issue.
- R2: A slot dispatched with both sources ready is granted in the cycle after the dispatch write.
- R3: A broadcast tag that equals a slot's left or right source tag makes that source ready at the next clock edge. A slot with only one ready source never issues.
- R4: Each cycle up to NUM_FU distinct slots are granted, in ascending index order. Unit 0 takes the lowest requesting index, unit 1 the next one, and a higher unit is used only when all lower units are used.
- R5: When a slot whose class is single-cycle (class code 1) is granted, a slot waiting on its result tag is granted in the very next cycle.
- R6: A multi-cycle producer (class code 0) wakes nobody when it is granted. Its dependents are granted in the cycle after its tag appears on an external broadcast port.
- R7: A dispatch write compares its source tags against the broadcasts of the same cycle, both the external ones and the early ones from granted producers, so a wakeup in that cycle is not lost.
- R8: A granted load (class code 2) wakes its dependents speculatively, and they may be granted the next cycle. A slot granted while holding a speculative source stays in the window and is not granted again.
- R9: A load outcome reported as a hit (miss flag 0) for a slot's speculative tag releases that slot, so a later miss or broadcast on the same tag cannot make it issue again.
- R10: A load outcome reported as a miss (miss flag 1) clears the matching speculative sources and cancels the issue of their slots. A slot with such a source cannot be granted in the miss cycle. Those slots are granted again in the cycle after the load's real tag is broadcast.
- R11: A slot granted with no speculative source leaves the window at that clock edge and is never granted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| disp_we | input | 1 | Write a new instruction into slot disp_idx |
| disp_idx | input | $clog2(ENTRIES) | Slot written by the dispatch |
| disp_tag_l | input | TAG_W | Left source tag |
| disp_rdy_l | input | 1 | Left source already available |
| disp_tag_r | input | TAG_W | Right source tag |
| disp_rdy_r | input | 1 | Right source already available |
| disp_dst | input | TAG_W | Result tag of the instruction |
| disp_kind | input | 2 | Class: 0 multi-cycle, 1 single-cycle, 2 load |
| bc_valid | input | NUM_BC | Per-port valid of the external result broadcasts |
| bc_tag | input | NUM_BC*TAG_W | External broadcast tags, port b in bits [b*TAG_W +: TAG_W] |
| res_valid | input | 1 | A load outcome is reported this cycle |
| res_miss | input | 1 | The reported load missed (1) or hit (0) |
| res_tag | input | TAG_W | Result tag of the load whose outcome is reported |
| iss_valid | output | NUM_FU | Unit f received a grant this cycle |
| iss_idx | output | NUM_FU*$clog2(ENTRIES) | Granted slot for unit f in bits [f*$clog2(ENTRIES) +: $clog2(ENTRIES)] |

## Verification
The grants are tried in several situations. In one, slots become ready in scattered order through one shared tag, which shows whether the selection ranks slots by index or by arrival. Single-cycle, multi-cycle and load producers are each paired with a waiting dependent; the cycle in which that dependent is granted shows which wakeup path was taken. Load outcomes are sent as a hit followed by a late miss on the same tag, and as a miss that arrives while a second dependent has only just become ready. The first case shows whether a slot was really released; the second covers the cancel path and the blocking of a request in the miss cycle. Dispatches that coincide with an early or an external broadcast show whether a same-cycle wakeup is kept.

// File: rtl/iq_pkg.sv
// Package: types shared by the issue window slots and the top level.
// Assumes: the class code values are fixed and known to the dispatch logic.
package iq_pkg;

    // Operation class of a queued instruction; decides the wakeup path.
    typedef enum logic [1:0] {
        OP_MULTI  = 2'd0,   // result broadcast later from outside
        OP_SINGLE = 2'd1,   // result tag announced when granted
        OP_LOAD   = 2'd2    // announced when granted, assuming a hit
    } op_kind_e;

endpackage

// File: rtl/iq_arb_tree.sv
// Module: lowest-index-first selector built as a binary tree of arbiter
// cells. Each cell ORs the requests of its subtree upward (anyreq) and
// passes the enable downward, to its left child first.
// Assumes: N is a power of two, at least 2. clk/rst_n serve only the checks.
module iq_arb_tree #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         anyreq
);

    // Heap numbering: node 1 is the root, node n has children 2n and 2n+1,
    // and the leaves are nodes N..2N-1.
    logic [2*N-1:1] any_n;
    logic [2*N-1:1] en_n;

    // Leaves: a request enters the tree, the leaf enable is the grant.
    for (genvar i = 0; i < N; i++) begin : g_leaf
        assign any_n[N+i] = req[i];
        assign gnt[i]     = en_n[N+i];
    end

    // Inner cells: collect requests upward and steer the enable downward.
    for (genvar n = 1; n < N; n++) begin : g_cell
        assign any_n[n]     = any_n[2*n] | any_n[2*n+1];
        assign en_n[2*n]    = en_n[n] & any_n[2*n];
        assign en_n[2*n+1]  = en_n[n] & ~any_n[2*n] & any_n[2*n+1];
    end

    // Root: the selector is always allowed to grant.
    assign en_n[1] = 1'b1;
    assign anyreq  = any_n[1];

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));                                   // R4
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);                               // R4
    AST_ANY_GETS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($countones(gnt) == 1));           // R4

endmodule

// File: rtl/iq_entry.sv
// Module: one slot of the issue window. It holds two source tags with
// ready and speculative flags, matches them against the broadcasts of
// the cycle, raises a request when both sources are ready, and handles
// the hit/miss outcome of the load that woke a speculative source.
// Assumes: a speculative flag is always paired with its tag, which equals
// the load's result tag, so the outcome is matched on the source tag.
module iq_entry
    import iq_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int NUM_WK = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [TAG_W-1:0]        wr_tag_l,
    input  logic                    wr_rdy_l,
    input  logic [TAG_W-1:0]        wr_tag_r,
    input  logic                    wr_rdy_r,
    input  logic [TAG_W-1:0]        wr_dst,
    input  op_kind_e                wr_kind,
    input  logic [NUM_WK-1:0]       wk_valid,
    input  logic [NUM_WK*TAG_W-1:0] wk_tag,
    input  logic [NUM_WK-1:0]       wk_spec,
    input  logic                    res_valid,
    input  logic                    res_miss,
    input  logic [TAG_W-1:0]        res_tag,
    input  logic                    grant,
    output logic                    req,
    output logic [TAG_W-1:0]        dst,
    output op_kind_e                kind
);

    logic             valid_q, issued_q;
    logic [TAG_W-1:0] tag_l_q, tag_r_q, dst_q;
    logic             rdy_l_q, rdy_r_q, spec_l_q, spec_r_q;
    op_kind_e         kind_q;

    logic             valid_d, issued_d;
    logic [TAG_W-1:0] tag_l_d, tag_r_d, dst_d;
    logic             rdy_l_d, rdy_r_d, spec_l_d, spec_r_d;
    op_kind_e         kind_d;

    // bit 1: some broadcast matches; bit 0: a non-speculative one matches
    logic [1:0] pb_l, pb_r, pb_wl, pb_wr;
    logic       out_l, out_r, squash;

    // Compare one tag against every broadcast of this cycle.
    function automatic logic [1:0] probe(
        input logic [TAG_W-1:0]        t,
        input logic [NUM_WK-1:0]       v,
        input logic [NUM_WK*TAG_W-1:0] tags,
        input logic [NUM_WK-1:0]       sp
    );
        logic [1:0] r;
        r = 2'b00;
        for (int w = 0; w < NUM_WK; w++) begin
            if (v[w] && tags[w*TAG_W +: TAG_W] == t) begin
                r[1] = 1'b1;
                if (!sp[w]) r[0] = 1'b1;
            end
        end
        return r;
    endfunction

    // Tag matching for the stored sources and for an incoming write.
    always_comb begin
        pb_l  = probe(tag_l_q,  wk_valid, wk_tag, wk_spec);
        pb_r  = probe(tag_r_q,  wk_valid, wk_tag, wk_spec);
        pb_wl = probe(wr_tag_l, wk_valid, wk_tag, wk_spec);
        pb_wr = probe(wr_tag_r, wk_valid, wk_tag, wk_spec);
    end

    // Load outcome aimed at a speculative source of this slot.
    assign out_l  = res_valid && spec_l_q && (tag_l_q == res_tag);
    assign out_r  = res_valid && spec_r_q && (tag_r_q == res_tag);
    assign squash = res_miss && (out_l || out_r);

    // Request: live, not yet issued, both sources ready, no miss right now.
    assign req  = valid_q && !issued_q && rdy_l_q && rdy_r_q && !squash;
    assign dst  = dst_q;
    assign kind = kind_q;

    // Next state: outcome handling, wakeup, issue tracking, release, write.
    always_comb begin
        tag_l_d  = tag_l_q;
        tag_r_d  = tag_r_q;
        dst_d    = dst_q;
        kind_d   = kind_q;
        rdy_l_d  = rdy_l_q;
        rdy_r_d  = rdy_r_q;
        spec_l_d = spec_l_q;
        spec_r_d = spec_r_q;
        if (out_l) begin
            spec_l_d = 1'b0;
            if (res_miss) rdy_l_d = 1'b0;
        end
        if (out_r) begin
            spec_r_d = 1'b0;
            if (res_miss) rdy_r_d = 1'b0;
        end
        if (!rdy_l_d && pb_l[1]) begin
            rdy_l_d  = 1'b1;
            spec_l_d = !pb_l[0];
        end
        if (!rdy_r_d && pb_r[1]) begin
            rdy_r_d  = 1'b1;
            spec_r_d = !pb_r[0];
        end
        issued_d = (issued_q || grant) && !squash;
        valid_d  = valid_q && !(issued_d && !spec_l_d && !spec_r_d);
        if (wr) begin
            valid_d  = 1'b1;
            issued_d = 1'b0;
            tag_l_d  = wr_tag_l;
            tag_r_d  = wr_tag_r;
            dst_d    = wr_dst;
            kind_d   = wr_kind;
            rdy_l_d  = wr_rdy_l || pb_wl[1];
            spec_l_d = !wr_rdy_l && pb_wl[1] && !pb_wl[0];
            rdy_r_d  = wr_rdy_r || pb_wr[1];
            spec_r_d = !wr_rdy_r && pb_wr[1] && !pb_wr[0];
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            issued_q <= 1'b0;
            tag_l_q  <= '0;
            tag_r_q  <= '0;
            dst_q    <= '0;
            kind_q   <= OP_MULTI;
            rdy_l_q  <= 1'b0;
            rdy_r_q  <= 1'b0;
            spec_l_q <= 1'b0;
            spec_r_q <= 1'b0;
        end else begin
            valid_q  <= valid_d;
            issued_q <= issued_d;
            tag_l_q  <= tag_l_d;
            tag_r_q  <= tag_r_d;
            dst_q    <= dst_d;
            kind_q   <= kind_d;
            rdy_l_q  <= rdy_l_d;
            rdy_r_q  <= rdy_r_d;
            spec_l_q <= spec_l_d;
            spec_r_q <= spec_r_d;
        end
    end

    AST_WAKE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !rdy_l_q && pb_l[1] && !wr |=> rdy_l_q);               // R3
    AST_WAKE_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q && !rdy_r_q && pb_r[1] && !wr |=> rdy_r_q);               // R3
    AST_FREE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        grant && !spec_l_q && !spec_r_q && !wr |=> !valid_q);             // R11
    AST_SPEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        grant && (spec_l_q || spec_r_q) && !res_valid && !wr
        |=> valid_q && issued_q);                                          // R8
    AST_SQUASH_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        squash && !wr |=> valid_q && !issued_q);                           // R10
    AST_GRANT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req);                                                    // R4

endmodule

// File: rtl/iq_wakeup_select.sv
// Module: issue window top. It holds ENTRIES slots and applies NUM_FU
// selection stages in sequence, each on the requests left by the ones
// before it. Granted single-cycle ops and loads put their result tags on
// internal broadcast lanes in the same cycle; loads mark those lanes
// speculative.
// Assumes: ENTRIES is a power of two; dispatch does not write a live
// slot; NUM_FU <= ENTRIES.
module iq_wakeup_select
    import iq_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 6,
    parameter int NUM_FU  = 2,
    parameter int NUM_BC  = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    disp_we,
    input  logic [IDX_W-1:0]        disp_idx,
    input  logic [TAG_W-1:0]        disp_tag_l,
    input  logic                    disp_rdy_l,
    input  logic [TAG_W-1:0]        disp_tag_r,
    input  logic                    disp_rdy_r,
    input  logic [TAG_W-1:0]        disp_dst,
    input  logic [1:0]              disp_kind,
    input  logic [NUM_BC-1:0]       bc_valid,
    input  logic [NUM_BC*TAG_W-1:0] bc_tag,
    input  logic                    res_valid,
    input  logic                    res_miss,
    input  logic [TAG_W-1:0]        res_tag,
    output logic [NUM_FU-1:0]       iss_valid,
    output logic [NUM_FU*IDX_W-1:0] iss_idx
);

    localparam int NUM_WK = NUM_BC + NUM_FU;

    logic [ENTRIES-1:0]      req_vec;
    logic [ENTRIES-1:0]      ent_grant;
    logic [TAG_W-1:0]        ent_dst  [ENTRIES];
    op_kind_e                ent_kind [ENTRIES];
    logic [NUM_WK-1:0]       wk_valid;
    logic [NUM_WK*TAG_W-1:0] wk_tag;
    logic [NUM_WK-1:0]       wk_spec;

    // External broadcasts occupy the low lanes and are never speculative.
    assign wk_valid[NUM_BC-1:0]       = bc_valid;
    assign wk_tag[NUM_BC*TAG_W-1:0]   = bc_tag;
    assign wk_spec[NUM_BC-1:0]        = '0;

    // Window slots.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        iq_entry #(
            .TAG_W  (TAG_W),
            .NUM_WK (NUM_WK)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (disp_we && (disp_idx == IDX_W'(i))),
            .wr_tag_l  (disp_tag_l),
            .wr_rdy_l  (disp_rdy_l),
            .wr_tag_r  (disp_tag_r),
            .wr_rdy_r  (disp_rdy_r),
            .wr_dst    (disp_dst),
            .wr_kind   (op_kind_e'(disp_kind)),
            .wk_valid  (wk_valid),
            .wk_tag    (wk_tag),
            .wk_spec   (wk_spec),
            .res_valid (res_valid),
            .res_miss  (res_miss),
            .res_tag   (res_tag),
            .grant     (ent_grant[i]),
            .req       (req_vec[i]),
            .dst       (ent_dst[i]),
            .kind      (ent_kind[i])
        );
    end

    // One selection stage per functional unit, chained by the taken mask.
    for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
        logic [ENTRIES-1:0] pool, gnt, taken;
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic [TAG_W-1:0]   early_tag;
        logic               early_v, early_s;

        if (f == 0) begin : g_first
            assign pool  = req_vec;
            assign taken = gnt;
        end else begin : g_next
            assign pool  = req_vec & ~g_fu[f-1].taken;
            assign taken = g_fu[f-1].taken | gnt;
        end

        iq_arb_tree #(.N(ENTRIES)) u_arb (
            .clk    (clk),
            .rst_n  (rst_n),
            .req    (pool),
            .gnt    (gnt),
            .anyreq (hit)
        );

        // Encode the one-hot grant and pick the granted slot's early tag.
        always_comb begin
            idx       = '0;
            early_tag = '0;
            early_v   = 1'b0;
            early_s   = 1'b0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (gnt[i]) begin
                    idx       = idx | IDX_W'(i);
                    early_tag = early_tag | ent_dst[i];
                    early_v   = early_v | (ent_kind[i] != OP_MULTI);
                    early_s   = early_s | (ent_kind[i] == OP_LOAD);
                end
            end
        end

        assign iss_valid[f]                  = hit;
        assign iss_idx[f*IDX_W +: IDX_W]     = idx;
        assign wk_valid[NUM_BC+f]            = early_v;
        assign wk_tag[(NUM_BC+f)*TAG_W +: TAG_W] = early_tag;
        assign wk_spec[NUM_BC+f]             = early_s;

        if (f > 0) begin : g_chk
            AST_FU_FILL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[f] |-> iss_valid[f-1]);                          // R4
            AST_FU_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[f] |-> (iss_idx[f*IDX_W +: IDX_W] >
                                  iss_idx[(f-1)*IDX_W +: IDX_W]));         // R4
        end
    end

    // A slot is granted when any stage took it.
    assign ent_grant = g_fu[NUM_FU-1].taken;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (iss_valid == '0));                               // R1

endmodule

// File: tb/sim_iq_wakeup_select.sv
module sim_iq_wakeup_select;
    import iq_pkg::*;

    localparam int E  = 8;
    localparam int TW = 6;
    localparam int NF = 2;
    localparam int NB = 2;
    localparam int IW = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic            rst_n;
    logic            disp_we;
    logic [IW-1:0]   disp_idx;
    logic [TW-1:0]   disp_tag_l, disp_tag_r, disp_dst, res_tag;
    logic            disp_rdy_l, disp_rdy_r, res_valid, res_miss;
    logic [1:0]      disp_kind;
    logic [NB-1:0]   bc_valid;
    logic [NB*TW-1:0] bc_tag;
    logic [NF-1:0]   iss_valid;
    logic [NF*IW-1:0] iss_idx;

    iq_wakeup_select #(.ENTRIES(E), .TAG_W(TW), .NUM_FU(NF), .NUM_BC(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .disp_we(disp_we), .disp_idx(disp_idx),
        .disp_tag_l(disp_tag_l), .disp_rdy_l(disp_rdy_l),
        .disp_tag_r(disp_tag_r), .disp_rdy_r(disp_rdy_r),
        .disp_dst(disp_dst), .disp_kind(disp_kind),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .res_valid(res_valid), .res_miss(res_miss), .res_tag(res_tag),
        .iss_valid(iss_valid), .iss_idx(iss_idx));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // Behavioural reference state, one record per slot.
    bit m_v[E], m_is[E], m_rl[E], m_sl[E], m_rr[E], m_sr[E];
    int m_tl[E], m_tr[E], m_dst[E], m_kind[E];
    int wk_t[NB+NF];
    bit wk_s[NB+NF];
    int wk_n;

    // Hand-computed expectation for the next sampled cycle.
    bit h_on = 0;
    bit h_v[NF];
    int h_i[NF];

    task automatic chk(bit ok, string lbl, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
        end
    endtask

    function automatic void src_upd(int tag, inout bit r, inout bit s, inout bit sq);
        bit any = 0, ns = 0;
        if (s && res_valid && int'(res_tag) == tag) begin
            s = 0;
            if (res_miss) begin r = 0; sq = 1; end
        end
        for (int k = 0; k < wk_n; k++)
            if (wk_t[k] == tag) begin any = 1; if (!wk_s[k]) ns = 1; end
        if (!r && any) begin r = 1; s = !ns; end
    endfunction

    function automatic void src_new(int tag, bit rdy, output bit r, output bit s);
        bit any = 0, ns = 0;
        for (int k = 0; k < wk_n; k++)
            if (wk_t[k] == tag) begin any = 1; if (!wk_s[k]) ns = 1; end
        r = rdy || any;
        s = !rdy && any && !ns;
    endfunction

    // One clock: predict, compare before the edge, advance the model.
    task automatic tick(string lbl);
        bit gv[NF];
        int gi[NF];
        int nb = 0;
        #8;
        for (int f = 0; f < NF; f++) begin gv[f] = 0; gi[f] = 0; end
        for (int i = 0; i < E; i++) begin
            bit sq, rq;
            sq = res_valid && res_miss &&
                 ((m_sl[i] && m_tl[i] == int'(res_tag)) || (m_sr[i] && m_tr[i] == int'(res_tag)));
            rq = m_v[i] && !m_is[i] && m_rl[i] && m_rr[i] && !sq;
            if (rq && nb < NF) begin gv[nb] = 1; gi[nb] = i; nb++; end
        end
        for (int f = 0; f < NF; f++) begin
            chk(iss_valid[f] == gv[f], lbl, $sformatf("model fu%0d valid", f), int'(iss_valid[f]), int'(gv[f]));
            if (gv[f]) chk(int'(iss_idx[f*IW +: IW]) == gi[f], lbl,
                           $sformatf("model fu%0d idx", f), int'(iss_idx[f*IW +: IW]), gi[f]);
            if (h_on) begin
                chk(iss_valid[f] == h_v[f], lbl, $sformatf("fu%0d valid", f), int'(iss_valid[f]), int'(h_v[f]));
                if (h_v[f]) chk(int'(iss_idx[f*IW +: IW]) == h_i[f], lbl,
                                $sformatf("fu%0d idx", f), int'(iss_idx[f*IW +: IW]), h_i[f]);
            end
        end
        h_on = 0;
        wk_n = 0;
        for (int b = 0; b < NB; b++)
            if (bc_valid[b]) begin wk_t[wk_n] = int'(bc_tag[b*TW +: TW]); wk_s[wk_n] = 0; wk_n++; end
        for (int f = 0; f < NF; f++)
            if (gv[f] && m_kind[gi[f]] != 0) begin
                wk_t[wk_n] = m_dst[gi[f]]; wk_s[wk_n] = (m_kind[gi[f]] == 2); wk_n++;
            end
        for (int i = 0; i < E; i++) begin
            bit g, sq;
            g  = (gv[0] && gi[0] == i) || (gv[1] && gi[1] == i);
            sq = 0;
            if (disp_we && int'(disp_idx) == i) begin
                m_v[i] = 1; m_is[i] = 0;
                m_tl[i] = int'(disp_tag_l); m_tr[i] = int'(disp_tag_r);
                m_dst[i] = int'(disp_dst); m_kind[i] = int'(disp_kind);
                src_new(m_tl[i], disp_rdy_l, m_rl[i], m_sl[i]);
                src_new(m_tr[i], disp_rdy_r, m_rr[i], m_sr[i]);
            end else if (m_v[i]) begin
                src_upd(m_tl[i], m_rl[i], m_sl[i], sq);
                src_upd(m_tr[i], m_rr[i], m_sr[i], sq);
                m_is[i] = (m_is[i] || g) && !sq;
                if (m_is[i] && !m_sl[i] && !m_sr[i]) m_v[i] = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        disp_we = 0; bc_valid = '0; res_valid = 0; res_miss = 0;
    endtask

    task automatic want(bit v0, int i0, bit v1, int i1);
        h_on = 1; h_v[0] = v0; h_i[0] = i0; h_v[1] = v1; h_i[1] = i1;
    endtask

    task automatic disp(int idx, int tl, bit rl, int tr, bit rr, int dst, int kind);
        disp_we = 1; disp_idx = IW'(idx);
        disp_tag_l = TW'(tl); disp_rdy_l = rl;
        disp_tag_r = TW'(tr); disp_rdy_r = rr;
        disp_dst = TW'(dst); disp_kind = 2'(kind);
    endtask

    task automatic bcast(int port, int tag);
        bc_valid[port] = 1; bc_tag[port*TW +: TW] = TW'(tag);
    endtask

    task automatic resolve(int tag, bit miss);
        res_valid = 1; res_miss = miss; res_tag = TW'(tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #4_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; disp_we = 0; disp_idx = '0; disp_tag_l = '0; disp_tag_r = '0;
        disp_rdy_l = 0; disp_rdy_r = 0; disp_dst = '0; disp_kind = '0;
        bc_valid = '0; bc_tag = '0; res_valid = 0; res_miss = 0; res_tag = '0;
        for (int i = 0; i < E; i++) begin
            m_v[i] = 0; m_is[i] = 0; m_rl[i] = 0; m_sl[i] = 0; m_rr[i] = 0; m_sr[i] = 0;
            m_tl[i] = 0; m_tr[i] = 0; m_dst[i] = 0; m_kind[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(iss_valid == '0, "R1", "issue during reset", int'(iss_valid), 0);
        #1 rst_n = 1;
        want(0, 0, 0, 0); tick("R1");

        // R2 / R11: ready at dispatch, issued next cycle, then gone.
        disp(3, 1, 1, 2, 1, 10, 0); want(0, 0, 0, 0); tick("R2");
        want(1, 3, 0, 0); tick("R2");
        want(0, 0, 0, 0); tick("R11");

        // R3: wake the left source, then the right one on another port.
        disp(2, 20, 0, 21, 1, 11, 0); tick("R3");
        want(0, 0, 0, 0); tick("R3");
        bcast(0, 20); want(0, 0, 0, 0); tick("R3");
        want(1, 2, 0, 0); tick("R3");
        disp(5, 23, 1, 22, 0, 12, 0); tick("R3");
        bcast(1, 22); want(0, 0, 0, 0); tick("R3");
        want(1, 5, 0, 0); tick("R3");

        // R4: four slots woken together in scattered dispatch order.
        disp(6, 30, 0, 31, 1, 20, 0); tick("R4");
        disp(1, 30, 0, 31, 1, 21, 0); tick("R4");
        disp(4, 30, 0, 31, 1, 22, 0); tick("R4");
        disp(0, 30, 0, 31, 1, 23, 0); tick("R4");
        bcast(0, 30); want(0, 0, 0, 0); tick("R4");
        want(1, 0, 1, 1); tick("R4");
        want(1, 4, 1, 6); tick("R4");
        want(0, 0, 0, 0); tick("R4");

        // R5: single-cycle producer wakes its dependent back to back.
        disp(1, 40, 0, 2, 1, 13, 0); tick("R5");
        disp(0, 3, 1, 4, 1, 40, 1); tick("R5");
        want(1, 0, 0, 0); tick("R5");
        want(1, 1, 0, 0); tick("R5");
        tick("R5");

        // R6: multi-cycle producer waits for the external broadcast.
        disp(3, 41, 0, 2, 1, 14, 0); tick("R6");
        disp(2, 3, 1, 3, 1, 41, 0); tick("R6");
        want(1, 2, 0, 0); tick("R6");
        want(0, 0, 0, 0); tick("R6");
        want(0, 0, 0, 0); tick("R6");
        bcast(0, 41); want(0, 0, 0, 0); tick("R6");
        want(1, 3, 0, 0); tick("R6");

        // R7: dispatch in the same cycle as an early and an external wakeup.
        disp(4, 1, 1, 1, 1, 42, 1); tick("R7");
        disp(5, 42, 0, 1, 1, 15, 0); want(1, 4, 0, 0); tick("R7");
        want(1, 5, 0, 0); tick("R7");
        disp(6, 43, 0, 1, 1, 16, 0); bcast(0, 43); want(0, 0, 0, 0); tick("R7");
        want(1, 6, 0, 0); tick("R7");

        // R8 / R9: load hit releases the speculative dependent for good.
        disp(1, 50, 0, 1, 1, 17, 0); tick("R8");
        disp(0, 1, 1, 1, 1, 50, 2); tick("R8");
        want(1, 0, 0, 0); tick("R8");
        want(1, 1, 0, 0); tick("R8");
        want(0, 0, 0, 0); tick("R8");
        resolve(50, 0); want(0, 0, 0, 0); tick("R9");
        tick("R9");
        resolve(50, 1); want(0, 0, 0, 0); tick("R9");
        bcast(0, 50); want(0, 0, 0, 0); tick("R9");
        want(0, 0, 0, 0); tick("R9");

        // R10: miss squashes one issued dependent and blocks a fresh one.
        disp(3, 51, 0, 1, 1, 18, 0); tick("R10");
        disp(4, 51, 0, 52, 0, 19, 0); tick("R10");
        disp(2, 1, 1, 1, 1, 51, 2); tick("R10");
        want(1, 2, 0, 0); tick("R10");
        bcast(0, 52); want(1, 3, 0, 0); tick("R10");
        resolve(51, 1); want(0, 0, 0, 0); tick("R10");
        want(0, 0, 0, 0); tick("R10");
        bcast(0, 51); want(0, 0, 0, 0); tick("R10");
        want(1, 3, 1, 4); tick("R10");
        want(0, 0, 0, 0); tick("R11");
        tick("R11");

        done = 1;
        summary();
        $finish;
    end

endmodule